// File: doc/BRIEF.md
# Reserving Priority Bus Arbiter

This block decides which of several masters on a shared parallel bus owns it, and lines up the next owner while the current owner is still moving data. One waiting master may hold a reservation during the current transfer. When that transfer's handshake completes, ownership passes to the reserved master on the next clock, with no idle arbitration cycle in between. When several masters compete for the reservation, or for ownership of an idle bus, the lowest slot index wins.

The owner marks its transfer with a strobe and the slave answers with an acknowledge. The cycle in which both are high ends the transfer and the ownership. Each master sees two one-hot grant lines: one says it owns the bus, the other says it holds the reservation. Address and data paths are outside this block.

Top module: `resv_bus_arbiter`

## Requirements
- R1: After reset, no master holds ownership or a reservation.
- R2: While the bus has no owner, the requesting master with the lowest index becomes owner on the next clock, and no reservation is granted in that cycle.
- R3: While the bus is owned and no reservation is held, the lowest-index requester other than the owner receives the reservation on the next clock.
- R4: A transfer ends only in a cycle where the bus has an owner and `xfer_strb` and `xfer_ack` are both 1. Until then, ownership stays unchanged. The strobe and acknowledge have no effect while the bus is idle.
- R5: When a transfer ends while a reservation is held and the reserved master is still requesting, that master owns the bus on the next clock and the reservation clears.
- R6: When a transfer ends with no reservation, or with a reserved master that has stopped requesting, the bus is idle on the next clock with no reservation.
- R7: A granted reservation stays with its master while that master keeps requesting and the transfer has not ended, even if a lower-index master starts to request.
- R8: If the reserved master drops its request before it takes ownership, the reservation clears on the next clock. Arbitration for a new reservation happens on the clock after that.
- R9: `own_gnt` and `resv_gnt` are each one-hot or zero, and never grant the same master.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | N | Request line per master; bit 0 has the highest priority |
| xfer_strb | input | 1 | Owner's transfer strobe |
| xfer_ack | input | 1 | Slave acknowledge; with the strobe, it ends the transfer |
| own_gnt | output | N | One-hot ownership grant |
| resv_gnt | output | N | One-hot reservation grant |

## Verification
The grant state is held in the two output registers, so a wrong internal state appears at the ports in the very next cycle. Examples are a lost reservation, a second owner, or a reservation moved to a late higher-priority requester. The bench compares both grant vectors after every clock against a queue of expected values. It drives the cases where the reserved master withdraws, where a handshake arrives on an idle bus, and where the acknowledge comes without a strobe. A missed handover shows up as an idle bus one cycle after the acknowledge. A wrong re-arbitration shows up in the cycle directly after a request is dropped.

// File: rtl/resv_bus_arbiter.sv
module resv_bus_arbiter #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] bus_req,
  input  logic         xfer_strb,
  input  logic         xfer_ack,
  output logic [N-1:0] own_gnt,
  output logic [N-1:0] resv_gnt
);

  logic [N-1:0] own_q, resv_q, own_d, resv_d;
  logic [N-1:0] idle_pick, resv_cand, resv_pick;
  logic         owned, held, done, resv_live;

  assign owned     = |own_q;
  assign held      = |resv_q;
  assign done      = owned & xfer_strb & xfer_ack;
  assign resv_live = |(resv_q & bus_req);

  // lowest set bit wins: x & -x
  assign idle_pick = bus_req & (~bus_req + 1'b1);
  assign resv_cand = bus_req & ~own_q;
  assign resv_pick = resv_cand & (~resv_cand + 1'b1);

  always_comb begin
    if (!owned)    own_d = idle_pick;
    else if (done) own_d = resv_q & bus_req;
    else           own_d = own_q;
  end

  always_comb begin
    if (!owned || done) resv_d = '0;
    else if (held)      resv_d = resv_live ? resv_q : '0;
    else                resv_d = resv_pick;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      own_q  <= '0;
      resv_q <= '0;
    end else begin
      own_q  <= own_d;
      resv_q <= resv_d;
    end
  end

  assign own_gnt  = own_q;
  assign resv_gnt = resv_q;

  // R9
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(own_gnt) && $onehot0(resv_gnt) && ((own_gnt & resv_gnt) == '0));

  // R4
  own_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|own_gnt && !(xfer_strb && xfer_ack)) |=> $stable(own_gnt));

  // R5
  handover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|own_gnt && xfer_strb && xfer_ack && |(resv_gnt & bus_req))
      |=> (own_gnt == $past(resv_gnt)) && (resv_gnt == '0));

  // R6
  go_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|own_gnt && xfer_strb && xfer_ack && !(|(resv_gnt & bus_req)))
      |=> (own_gnt == '0) && (resv_gnt == '0));

  // R7
  resv_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(resv_gnt & bus_req) && !(xfer_strb && xfer_ack)) |=> $stable(resv_gnt));

  // R8
  resv_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|resv_gnt && !(|(resv_gnt & bus_req))) |=> (resv_gnt == '0));

endmodule

// File: tb/sim_resv_bus_arbiter.sv
`timescale 1ns/100ps
module sim_resv_bus_arbiter;
  localparam int N = 8;

  typedef struct {
    logic [N-1:0] own;
    logic [N-1:0] resv;
    string        tag;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] bus_req = '0;
  logic         xfer_strb = 1'b0;
  logic         xfer_ack = 1'b0;
  logic [N-1:0] own_gnt, resv_gnt;

  exp_t sb[$];
  int   checks = 0;
  int   fails  = 0;
  bit   done_run = 1'b0;

  always #2.5 clk = ~clk;

  resv_bus_arbiter #(.N(N)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req),
    .xfer_strb(xfer_strb), .xfer_ack(xfer_ack),
    .own_gnt(own_gnt), .resv_gnt(resv_gnt)
  );

  task automatic step(input logic [N-1:0] r, input logic s, input logic a,
                      input logic [N-1:0] eo, input logic [N-1:0] er, input string tag);
    exp_t e;
    @(negedge clk);
    bus_req = r; xfer_strb = s; xfer_ack = a;
    e.own = eo; e.resv = er; e.tag = tag;
    sb.push_back(e);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        e = sb.pop_front();
        checks++;
        if (own_gnt !== e.own || resv_gnt !== e.resv) begin
          fails++;
          $display("FAIL %s: own=%b resv=%b expected own=%b resv=%b",
                   e.tag, own_gnt, resv_gnt, e.own, e.resv);
        end
      end
    end
  end

  initial begin : watchdog
    #100000;
    if (!done_run) begin
      fails++; checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    checks++;
    if (own_gnt !== '0 || resv_gnt !== '0) begin
      fails++;
      $display("FAIL R1 reset: own=%b resv=%b expected own=0 resv=0", own_gnt, resv_gnt);
    end
    rst_n = 1'b1;
    step(8'b0000_1100, 0, 0, 8'b0000_0100, 8'b0,         "R2 idle pick");
    step(8'b0000_1100, 0, 0, 8'b0000_0100, 8'b0000_1000, "R3 reserve");
    step(8'b0000_1110, 1, 0, 8'b0000_0100, 8'b0000_1000, "R7 no preempt/R4 strobe only");
    step(8'b0000_1110, 1, 1, 8'b0000_1000, 8'b0,         "R5 handover");
    step(8'b0000_1010, 0, 0, 8'b0000_1000, 8'b0000_0010, "R3 owner excluded");
    step(8'b0000_1000, 0, 0, 8'b0000_1000, 8'b0,         "R8 drop clears");
    step(8'b0110_0000, 0, 0, 8'b0000_1000, 8'b0010_0000, "R8 rearbitrate");
    step(8'b0110_0000, 0, 1, 8'b0000_1000, 8'b0010_0000, "R4 ack without strobe");
    step(8'b0100_0000, 1, 1, 8'b0,         8'b0,         "R6 reserved withdrew at end");
    step(8'b0100_0000, 1, 1, 8'b0100_0000, 8'b0,         "R4 idle handshake ignored");
    step(8'b0000_0000, 1, 1, 8'b0,         8'b0,         "R6 end without reservation");
    step(8'b1111_1111, 0, 0, 8'b0000_0001, 8'b0,         "R2 all request");
    step(8'b1111_1111, 0, 0, 8'b0000_0001, 8'b0000_0010, "R3 next priority");
    step(8'b1111_1110, 1, 1, 8'b0000_0010, 8'b0,         "R5 handover two");
    step(8'b1111_1110, 0, 0, 8'b0000_0010, 8'b0000_0100, "R3 reserve after handover");
    step(8'b0000_0000, 1, 1, 8'b0,         8'b0,         "R6 idle after withdraw");
    step(8'b0000_0000, 0, 0, 8'b0,         8'b0,         "R9 quiet");
    @(negedge clk);
    @(negedge clk);
    done_run = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule